// File: doc/BRIEF.md
# Source-Synchronous Receive Startup Sequencer

This block brings up a clock-aligned DDR receive path in which a slave delay line is clocked by a master DLL's reference and feeds its own output back as that DLL's clock. The DLL in turn drives delay codes into the slave. If the slave accepts codes before the DLL has settled, the loop can chase itself and never converge. The sequencer breaks that loop at power-up. It holds the DLL in reset, then keeps it frozen and the slave's code-load enable inactive until lock has been qualified. It then loads one code and unfreezes the DLL.

After the loop is stable, the sequencer aligns the gearbox. It stops the edge clock, pulses the gearbox reset inside the stopped window and restarts the clock. Only then does it raise ready. While ready, an update request gives a short freeze and code-load refresh without dropping ready. Loss of lock sends the sequence back to waiting for lock.

Everything runs from the slow sync clock with an active-low asynchronous reset. The lock flag is asynchronous and is synchronized inside the block. The update request is synchronous to the sync clock.

Top module: `rx_start_seq`

## Requirements
- R1: While rst_ni is low, dll_rst_o=1, freeze_o=1, upd_en_no=1, clk_stop_o=0, ddr_rst_o=1 and ready_o=0.
- R2: After reset release, dll_rst_o stays high for exactly RST_CYC (default 8) sync clock cycles and then stays low.
- R3: dll_lock_i passes through SYNC_STAGES (default 2) flops and must be high on LOCK_CYC (default 16) consecutive synchronized samples to qualify. A shorter high glitch leaves all outputs at their lock-wait values.
- R4: Lock qualification yields exactly one cycle of upd_en_no=0 (active low) with freeze_o=1. With defaults this cycle is the 19th cycle after the first clock edge that samples dll_lock_i high.
- R5: freeze_o falls in the cycle directly after the initial update pulse.
- R6: From that same cycle, clk_stop_o is high for STOP_CYC (default 4) cycles. ddr_rst_o stays high for the first STOP_CYC/2 of them and is low for the rest.
- R7: ready_o rises in the cycle clk_stop_o falls. While ready_o is high, dll_rst_o, ddr_rst_o and clk_stop_o are low.
- R8: If the qualified lock is lost in any state after lock wait, the block returns to lock wait on the next edge with ready_o=0, freeze_o=1, ddr_rst_o=1. With defaults the return is the 4th cycle after dll_lock_i is first sampled low.
- R9: While ready and unfrozen, an update request sampled high gives one cycle with freeze_o=1 and upd_en_no=1, then one cycle with freeze_o=1 and upd_en_no=0, then freeze_o=0. ready_o stays 1 throughout.
- R10: An update request outside the ready state is ignored: in lock wait the outputs keep their lock-wait values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow sync clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dll_lock_i | input | 1 | DLL lock flag, asynchronous |
| upd_req_i | input | 1 | Delay-code refresh request, sync clock domain |
| dll_rst_o | output | 1 | DLL reset |
| freeze_o | output | 1 | DLL freeze |
| upd_en_no | output | 1 | Slave delay-code load enable, active low |
| clk_stop_o | output | 1 | Edge-clock stop |
| ddr_rst_o | output | 1 | DDR gearbox reset |
| ready_o | output | 1 | Receive path ready |

## Verification
Every output is decoded from registered state, so each result is due at fixed cycle offsets from its stimulus. Release of dll_rst_o comes 8 edges after reset. The update pulse comes 19 cycles after lock is first sampled: 2 synchronizer edges, 16 qualifying samples and 1 FSM edge. The gearbox window follows at offsets 1 to 4 after that, and the return to lock wait comes 4 cycles after lock is first sampled low. A refresh shows 1 and 2 cycles after the request is sampled. The bench computes these absolute cycle numbers from the stimulus times and queues one expected output vector per cycle. A monitor on the falling edge pops and compares each entry in the cycle it names, and any entry left in the queue counts as a mismatch.

// File: rtl/rx_seq_pkg.sv
package rx_seq_pkg;
  typedef enum logic [2:0] {
    ST_DLL_RST,
    ST_LOCK_WAIT,
    ST_UPD,
    ST_STOP,
    ST_READY,
    ST_RF_FRZ,
    ST_RF_UPD
  } seq_state_e;
endpackage

// File: rtl/rx_seq_lock_filt.sv
module rx_seq_lock_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYC    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  output logic lock_ok_o
);
  localparam int QW = $clog2(LOCK_CYC + 1);

  logic          lock_s;
  logic [QW-1:0] qual_q;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= 1'b0;
        else         s_q <= lock_i;
      end
      assign lock_s = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= {s_q[SYNC_STAGES-2:0], lock_i};
      end
      assign lock_s = s_q[SYNC_STAGES-1];
    end
  endgenerate

  // consecutive-high qualifier, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        qual_q <= '0;
    else if (!lock_s)                   qual_q <= '0;
    else if (qual_q != QW'(LOCK_CYC))   qual_q <= qual_q + 1'b1;
  end

  assign lock_ok_o = (qual_q == QW'(LOCK_CYC));
endmodule

// File: rtl/rx_seq_ctr.sv
module rx_seq_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_o <= '0;
    else if (clr_i)        cnt_o <= '0;
    else if (cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rx_seq_fsm.sv
module rx_seq_fsm
  import rx_seq_pkg::*;
#(
  parameter int RST_CYC  = 8,
  parameter int STOP_CYC = 4,
  parameter int CW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_ok_i,
  input  logic          upd_req_i,
  input  logic [CW-1:0] cnt_i,
  output seq_state_e    st_o,
  output logic          clr_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DLL_RST:   if (cnt_i == CW'(RST_CYC - 1)) st_d = ST_LOCK_WAIT;
      ST_LOCK_WAIT: if (lock_ok_i) st_d = ST_UPD;
      ST_UPD:       st_d = lock_ok_i ? ST_STOP : ST_LOCK_WAIT;
      ST_STOP: begin
        if (!lock_ok_i)                         st_d = ST_LOCK_WAIT;
        else if (cnt_i == CW'(STOP_CYC - 1))    st_d = ST_READY;
      end
      ST_READY: begin
        if (!lock_ok_i)     st_d = ST_LOCK_WAIT;
        else if (upd_req_i) st_d = ST_RF_FRZ;
      end
      ST_RF_FRZ:    st_d = lock_ok_i ? ST_RF_UPD : ST_LOCK_WAIT;
      ST_RF_UPD:    st_d = lock_ok_i ? ST_READY  : ST_LOCK_WAIT;
      default:      st_d = ST_DLL_RST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_DLL_RST;
    else         st_q <= st_d;
  end

  assign st_o  = st_q;
  assign clr_o = (st_d != st_q);
endmodule

// File: rtl/rx_seq_outdec.sv
module rx_seq_outdec
  import rx_seq_pkg::*;
#(
  parameter int STOP_CYC = 4,
  parameter int CW       = 4
) (
  input  seq_state_e    st_i,
  input  logic [CW-1:0] cnt_i,
  output logic          dll_rst_o,
  output logic          freeze_o,
  output logic          upd_en_no,
  output logic          clk_stop_o,
  output logic          ddr_rst_o,
  output logic          ready_o
);
  localparam int GB_HOLD = STOP_CYC / 2;

  always_comb begin
    dll_rst_o  = (st_i == ST_DLL_RST);
    freeze_o   = st_i inside {ST_DLL_RST, ST_LOCK_WAIT, ST_UPD, ST_RF_FRZ, ST_RF_UPD};
    upd_en_no  = !(st_i inside {ST_UPD, ST_RF_UPD});
    clk_stop_o = (st_i == ST_STOP);
    // gearbox reset released mid-way through the stopped window
    ddr_rst_o  = st_i inside {ST_DLL_RST, ST_LOCK_WAIT, ST_UPD} ||
                 ((st_i == ST_STOP) && (cnt_i < CW'(GB_HOLD)));
    ready_o    = st_i inside {ST_READY, ST_RF_FRZ, ST_RF_UPD};
  end
endmodule

// File: rtl/rx_start_seq.sv
module rx_start_seq
  import rx_seq_pkg::*;
#(
  parameter int RST_CYC     = 8,
  parameter int LOCK_CYC    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int STOP_CYC    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dll_lock_i,
  input  logic upd_req_i,
  output logic dll_rst_o,
  output logic freeze_o,
  output logic upd_en_no,
  output logic clk_stop_o,
  output logic ddr_rst_o,
  output logic ready_o
);
  localparam int MAX_WIN = (RST_CYC > STOP_CYC) ? RST_CYC : STOP_CYC;
  localparam int CW      = $clog2(MAX_WIN + 1);

  logic          lock_ok;
  logic          ctr_clr;
  logic [CW-1:0] cnt;
  seq_state_e    st;

  rx_seq_lock_filt #(.SYNC_STAGES(SYNC_STAGES), .LOCK_CYC(LOCK_CYC)) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(dll_lock_i), .lock_ok_o(lock_ok)
  );

  rx_seq_ctr #(.W(CW)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(ctr_clr), .cnt_o(cnt)
  );

  rx_seq_fsm #(.RST_CYC(RST_CYC), .STOP_CYC(STOP_CYC), .CW(CW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .lock_ok_i(lock_ok), .upd_req_i(upd_req_i),
    .cnt_i(cnt), .st_o(st), .clr_o(ctr_clr)
  );

  rx_seq_outdec #(.STOP_CYC(STOP_CYC), .CW(CW)) u_dec (
    .st_i(st), .cnt_i(cnt),
    .dll_rst_o(dll_rst_o), .freeze_o(freeze_o), .upd_en_no(upd_en_no),
    .clk_stop_o(clk_stop_o), .ddr_rst_o(ddr_rst_o), .ready_o(ready_o)
  );
endmodule

// File: rtl/rx_start_seq_chk.sv
module rx_start_seq_chk #(
  parameter int RST_CYC = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic lock_ok_i,
  input logic upd_req_i,
  input logic dll_rst_o,
  input logic freeze_o,
  input logic upd_en_no,
  input logic clk_stop_o,
  input logic ddr_rst_o,
  input logic ready_o
);
  localparam int SW = $clog2(RST_CYC + 1);
  logic [SW-1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        since_rst <= '0;
    else if (since_rst != SW'(RST_CYC)) since_rst <= since_rst + 1'b1;
  end

  // R2
  dll_rst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < SW'(RST_CYC)) |-> dll_rst_o);
  // R2
  dll_rst_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == SW'(RST_CYC)) |-> !dll_rst_o);
  // R3
  upd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(upd_en_no) |-> ($past(lock_ok_i) && freeze_o && !dll_rst_o));
  // R4
  upd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_no |=> upd_en_no);
  // R5
  unfreeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(freeze_o) |-> $past(!upd_en_no));
  // R6
  gb_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ddr_rst_o) |-> clk_stop_o);
  // R7
  stop_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(clk_stop_o) && $past(lock_ok_i)) |-> (ready_o && !ddr_rst_o));
  // R7
  ready_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!dll_rst_o && !ddr_rst_o && !clk_stop_o));
  // R8
  lock_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !lock_ok_i) |=> (!ready_o && freeze_o && ddr_rst_o));
  // R9
  refresh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !freeze_o && upd_req_i && lock_ok_i) |=> (ready_o && freeze_o && upd_en_no));
  // R10
  req_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && upd_req_i && !lock_ok_i) |=> upd_en_no);
endmodule

bind rx_start_seq rx_start_seq_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lock_ok_i(lock_ok), .upd_req_i(upd_req_i),
  .dll_rst_o(dll_rst_o), .freeze_o(freeze_o), .upd_en_no(upd_en_no),
  .clk_stop_o(clk_stop_o), .ddr_rst_o(ddr_rst_o), .ready_o(ready_o)
);

// File: tb/rx_start_seq_tb.sv
`timescale 1ns/1ps
module rx_start_seq_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0, dll_lock_i = 1'b0, upd_req_i = 1'b0;
  logic dll_rst_o, freeze_o, upd_en_no, clk_stop_o, ddr_rst_o, ready_o;

  rx_start_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .dll_lock_i(dll_lock_i), .upd_req_i(upd_req_i),
    .dll_rst_o(dll_rst_o), .freeze_o(freeze_o), .upd_en_no(upd_en_no),
    .clk_stop_o(clk_stop_o), .ddr_rst_o(ddr_rst_o), .ready_o(ready_o)
  );

  always #2.5 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  // {dll_rst, freeze, upd_en_n, stop, ddr_rst, ready}
  localparam logic [5:0] V_DRST = 6'b111010;
  localparam logic [5:0] V_LW   = 6'b011010;
  localparam logic [5:0] V_UPD  = 6'b010010;
  localparam logic [5:0] V_STA  = 6'b001110;
  localparam logic [5:0] V_STB  = 6'b001100;
  localparam logic [5:0] V_RDY  = 6'b001001;
  localparam logic [5:0] V_RFZ  = 6'b011001;
  localparam logic [5:0] V_RFU  = 6'b010001;

  wire [5:0] obs = {dll_rst_o, freeze_o, upd_en_no, clk_stop_o, ddr_rst_o, ready_o};

  typedef struct { int at; logic [5:0] v; string tag; } exp_t;
  exp_t sb[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(logic [5:0] got, logic [5:0] exp, string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %b expected %b", tag, cyc, got, exp);
    end
  endtask

  task automatic push(int from, int to, logic [5:0] v, string tag);
    for (int i = from; i <= to; i++) begin
      exp_t e;
      e.at = i; e.v = v; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic goto(int n);
    do @(negedge clk_i); while (cyc < n);
    #1;
  endtask

  // monitor
  always @(negedge clk_i) begin
    exp_t e;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      if (e.at < cyc) check(6'bxxxxxx, e.v, {e.tag, " (missed)"});
      else            check(obs, e.v, e.tag);
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int t, l1, r0, d0, l2;
    repeat (3) @(negedge clk_i);
    check(obs, V_DRST, "R1 reset state");
    t  = cyc;
    l1 = t + 25;
    r0 = l1 + 30;
    d0 = r0 + 10;
    l2 = d0 + 10;
    push(t + 1,  t + 7,  V_DRST, "R2 dll reset held");
    push(t + 8,  t + 11, V_LW,   "R2 dll reset released");
    push(t + 12, t + 18, V_LW,   "R10 request ignored in lock wait");
    push(t + 19, l1 + 18, V_LW,  "R3 glitch not qualified");
    push(l1 + 19, l1 + 19, V_UPD, "R4 initial update pulse");
    push(l1 + 20, l1 + 20, V_STA, "R5 unfreeze after pulse");
    push(l1 + 21, l1 + 21, V_STA, "R6 gearbox reset in stop");
    push(l1 + 22, l1 + 23, V_STB, "R6 gearbox released in stop");
    push(l1 + 24, r0,      V_RDY, "R7 ready");
    push(r0 + 1,  r0 + 1,  V_RFZ, "R9 refresh freeze");
    push(r0 + 2,  r0 + 2,  V_RFU, "R9 refresh pulse");
    push(r0 + 3,  d0 + 3,  V_RDY, "R9 back to ready");
    push(d0 + 4,  l2 + 18, V_LW,  "R8 lock loss");
    push(l2 + 19, l2 + 19, V_UPD, "R4 relock update");
    push(l2 + 20, l2 + 21, V_STA, "R6 relock stop");
    push(l2 + 22, l2 + 23, V_STB, "R6 relock release");
    push(l2 + 24, l2 + 30, V_RDY, "R7 relock ready");
    #1 rst_ni = 1'b1;

    goto(t + 10); upd_req_i = 1'b1;
    goto(t + 11); upd_req_i = 1'b0;
    goto(t + 14); dll_lock_i = 1'b1;
    goto(t + 19); dll_lock_i = 1'b0;
    goto(l1);     dll_lock_i = 1'b1;
    goto(r0);     upd_req_i = 1'b1;
    goto(r0 + 1); upd_req_i = 1'b0;
    goto(d0);     dll_lock_i = 1'b0;
    goto(l2);     dll_lock_i = 1'b1;
    goto(l2 + 31);

    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(6'bxxxxxx, e.v, {e.tag, " (never compared)"});
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule